// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Engine with Clock Suspend

This block is the column side of a synchronous DRAM-style memory device. It decodes READ and WRITE commands that carry a bank number and a starting column. It then walks a burst of consecutive column accesses on a 32-bit data bus: one beat per internal cycle, with the columns wrapping inside the aligned burst window. Write data is captured from `dq_in`. Read data comes out on `dq_out` with `dq_oe` high, after a selectable column latency. A small internal array holds the words, so a written burst can be read back through the same ports.

A clock-enable input gives clock suspend. While a burst is in progress (latency wait, write beats or read beats), sampling `cke` low on a rising edge suppresses the next internal edge. On a suppressed edge the engine ignores the command and write data on its inputs, keeps the read word on the bus and does not advance the column counter. The suppression is carried by a registered enable, so all logic stays on the single `clk` domain and the clock itself is never gated. When no burst is active, `cke` is disregarded.

Top module: `sdram_burst_engine`

## Requirements
- R1: After synchronous reset, `dq_oe` is 0, `dq_out` is 0 and the first edge after reset is an enabled internal edge.
- R2: Command code 2'b10 on `cmd` starts a write burst whose length is taken from `burst_sel` (0, 1, 2, 3 select 1, 2, 4, 8 beats). Beat 0 is the `dq_in` word at the command edge, and beat k is the `dq_in` word at the k-th enabled edge after it.
- R3: Command code 2'b01 starts a read burst, with `cas_sel` 0 giving latency 2 and 1 giving latency 3. Counting the command edge as enabled edge 0, beat 0 is driven after enabled edge L, and each later enabled edge drives the next beat. `dq_oe` stays high for exactly the burst's beats and falls at the following enabled edge.
- R4: Beat k of a burst of length B starting at column s addresses column (s & ~(B-1)) | ((s+k) & (B-1)), which wraps sequentially inside the aligned window.
- R5: While a burst is in progress, `cke` sampled low on a rising edge suppresses the next internal edge. `dq_out` and `dq_oe` hold their values and the column counter does not advance.
- R6: Write data present at a suppressed edge is not stored.
- R7: A command present at a suppressed edge is ignored.
- R8: Suppressed edges do not count toward the read latency.
- R9: With no burst in progress, `cke` low has no effect and a command on the next edge is accepted.
- R10: Once `cke` is sampled high, the following edge is a normal enabled edge and the burst continues where it stopped.
- R11: A READ or WRITE on an enabled edge ends any burst in progress, with `dq_oe` low after that edge unless new read data is due. Codes 2'b00 and 2'b11 are no-operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable sample input |
| cmd | input | 2 | Command: 00 no-op, 01 read, 10 write, 11 no-op |
| bank | input | 2 | Bank of the command |
| col | input | 4 | Starting column of the command |
| burst_sel | input | 2 | Burst length select, taken at the command |
| cas_sel | input | 1 | Read latency select, taken at the command |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Read data valid / output drive enable |

## Verification
The assertions check the following on every cycle:
- A suppressed internal edge leaves the sequencer state, `dq_out` and `dq_oe` unchanged.
- No memory write or read load is issued on a suppressed edge.
- `cke` low on an idle edge never suppresses the next edge.
- `cke` low during a burst always does.

Only the bench's directed scenarios can show the following:
- The values and order of the data words, including column wrap.
- Latency counted in enabled edges.
- A command arriving at a suppressed edge having no effect.
- A new command cutting off a burst in progress.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WRITE,
        SEQ_LAT,
        SEQ_READ
    } seq_e;

    typedef struct packed {
        seq_e       mode;
        logic [1:0] bl;
        logic       lat;
        logic [2:0] offs;
        logic [3:0] left;
    } seq_ctl_t;

    localparam seq_ctl_t SEQ_RESET = '{mode: SEQ_IDLE, bl: 2'd0, lat: 1'b0,
                                       offs: 3'd0, left: 4'd0};

    function automatic logic [3:0] burst_beats(input logic [1:0] sel);
        return 4'd1 << sel;
    endfunction

    function automatic logic [15:0] wrap_col(input logic [15:0] start,
                                             input logic [2:0]  offs,
                                             input logic [1:0]  sel);
        logic [15:0] mask;
        mask = (16'd1 << sel) - 16'd1;
        return (start & ~mask) | ((start + 16'(offs)) & mask);
    endfunction

endpackage

// File: rtl/sbe_cke.sv
module sbe_cke (
    input  logic clk,
    input  logic rst,
    input  logic cke_i,
    input  logic idle_i,
    output logic ce_o
);
    logic ce_q;

    always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b1;
        else     ce_q <= cke_i | idle_i;
    end

    assign ce_o = ce_q;

    p_idle_enabled_r9: assert property (@(posedge clk) disable iff (rst)
        idle_i |=> ce_o);

    p_suspend_next_r5: assert property (@(posedge clk) disable iff (rst)
        (!cke_i && !idle_i) |=> !ce_o);

endmodule

// File: rtl/sbe_seq.sv
module sbe_seq
    import sbe_pkg::*;
#(
    parameter int COL_W  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_i,
    input  logic [1:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [1:0]        bl_sel_i,
    input  logic              cl_sel_i,
    output logic              wr_req_o,
    output logic              rd_load_o,
    output logic              rd_stop_o,
    output logic [BANK_W-1:0] acc_bank_o,
    output logic [COL_W-1:0]  acc_col_o,
    output logic              idle_o
);
    seq_ctl_t          cur, nxt;
    logic [BANK_W-1:0] bank_q, bank_n;
    logic [COL_W-1:0]  start_q, start_n;
    cmd_e              cmd;
    logic              is_rd, is_wr;

    assign cmd   = cmd_e'(cmd_i);
    assign is_rd = (cmd == CMD_READ);
    assign is_wr = (cmd == CMD_WRITE);

    always_comb begin
        nxt        = cur;
        bank_n     = bank_q;
        start_n    = start_q;
        wr_req_o   = 1'b0;
        rd_load_o  = 1'b0;
        rd_stop_o  = 1'b0;
        acc_bank_o = bank_q;
        acc_col_o  = COL_W'(wrap_col(16'(start_q), cur.offs, cur.bl));
        if (ce_i) begin
            if (is_wr) begin
                wr_req_o   = 1'b1;
                rd_stop_o  = 1'b1;
                acc_bank_o = bank_i;
                acc_col_o  = col_i;
                bank_n     = bank_i;
                start_n    = col_i;
                nxt.bl     = bl_sel_i;
                nxt.offs   = 3'd1;
                nxt.left   = burst_beats(bl_sel_i) - 4'd1;
                nxt.mode   = (bl_sel_i == 2'd0) ? SEQ_IDLE : SEQ_WRITE;
            end else if (is_rd) begin
                rd_stop_o  = 1'b1;
                bank_n     = bank_i;
                start_n    = col_i;
                nxt.bl     = bl_sel_i;
                nxt.offs   = 3'd0;
                nxt.left   = burst_beats(bl_sel_i);
                nxt.lat    = cl_sel_i;
                nxt.mode   = SEQ_LAT;
            end else begin
                unique case (cur.mode)
                    SEQ_WRITE: begin
                        wr_req_o = 1'b1;
                        nxt.offs = cur.offs + 3'd1;
                        nxt.left = cur.left - 4'd1;
                        if (cur.left == 4'd1) nxt.mode = SEQ_IDLE;
                    end
                    SEQ_LAT: begin
                        if (!cur.lat) nxt.mode = SEQ_READ;
                        else          nxt.lat  = 1'b0;
                    end
                    SEQ_READ: begin
                        if (cur.left != 4'd0) begin
                            rd_load_o = 1'b1;
                            nxt.offs  = cur.offs + 3'd1;
                            nxt.left  = cur.left - 4'd1;
                        end else begin
                            rd_stop_o = 1'b1;
                            nxt.mode  = SEQ_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= SEQ_RESET;
            bank_q  <= '0;
            start_q <= '0;
        end else begin
            cur     <= nxt;
            bank_q  <= bank_n;
            start_q <= start_n;
        end
    end

    assign idle_o = (cur.mode == SEQ_IDLE);

    // R5, R7: a suppressed edge changes no sequencer state
    p_hold_state_r7: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> ($stable(cur) && $stable(start_q) && $stable(bank_q)));

endmodule

// File: rtl/sbe_store.sv
module sbe_store #(
    parameter int DQ_W   = 32,
    parameter int COL_W  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_i,
    input  logic              wr_req_i,
    input  logic              rd_load_i,
    input  logic              rd_stop_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DQ_W-1:0]   dq_i,
    output logic [DQ_W-1:0]   dq_o,
    output logic              oe_o
);
    localparam int ADDR_W = BANK_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DQ_W-1:0]   mem [DEPTH];
    logic [ADDR_W-1:0] addr;

    assign addr = {bank_i, col_i};

    always_ff @(posedge clk) begin
        if (wr_req_i) mem[addr] <= dq_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_o <= '0;
            oe_o <= 1'b0;
        end else if (rd_load_i) begin
            dq_o <= mem[addr];
            oe_o <= 1'b1;
        end else if (rd_stop_i) begin
            oe_o <= 1'b0;
        end
    end

    // R6: no access is requested on a suppressed edge
    p_no_access_suppressed_r6: assert property (@(posedge clk) disable iff (rst)
        !ce_i |-> (!wr_req_i && !rd_load_i));

    // R5: driven read data holds through a suppressed edge
    p_bus_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> ($stable(dq_o) && $stable(oe_o)));

endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine #(
    parameter int DQ_W   = 32,
    parameter int COL_W  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [1:0]        burst_sel,
    input  logic              cas_sel,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);
    logic              ce, idle;
    logic              wr_req, rd_load, rd_stop;
    logic [BANK_W-1:0] acc_bank;
    logic [COL_W-1:0]  acc_col;

    sbe_cke u_cke (
        .clk    (clk),
        .rst    (rst),
        .cke_i  (cke),
        .idle_i (idle),
        .ce_o   (ce)
    );

    sbe_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ce_i       (ce),
        .cmd_i      (cmd),
        .bank_i     (bank),
        .col_i      (col),
        .bl_sel_i   (burst_sel),
        .cl_sel_i   (cas_sel),
        .wr_req_o   (wr_req),
        .rd_load_o  (rd_load),
        .rd_stop_o  (rd_stop),
        .acc_bank_o (acc_bank),
        .acc_col_o  (acc_col),
        .idle_o     (idle)
    );

    sbe_store #(.DQ_W(DQ_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .ce_i      (ce),
        .wr_req_i  (wr_req),
        .rd_load_i (rd_load),
        .rd_stop_i (rd_stop),
        .bank_i    (acc_bank),
        .col_i     (acc_col),
        .dq_i      (dq_in),
        .dq_o      (dq_out),
        .oe_o      (dq_oe)
    );

    // R3: bus enable never rises while the sequencer is idle
    p_oe_rise_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> !idle);

endmodule

// File: tb/sdram_burst_engine_bench.sv
module sdram_burst_engine_bench;
    localparam logic [1:0] C_NOP = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_RSV = 2'b11;

    logic        clk = 1'b0;
    logic        rst, cke, cas_sel;
    logic [1:0]  cmd, bank, burst_sel;
    logic [3:0]  col;
    logic [31:0] dq_in, dq_out;
    logic        dq_oe;
    int          n_chk = 0, n_err = 0;
    logic [31:0] ref_mem [4][16];

    always #2 clk = ~clk;

    sdram_burst_engine u_sdram_burst_engine (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
        .burst_sel(burst_sel), .cas_sel(cas_sel), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic int wcol(input int s, input int k, input int bl);
        return (s & ~(bl - 1)) | ((s + k) & (bl - 1));
    endfunction

    task automatic drive(input logic [1:0] c, input logic [1:0] b, input logic [3:0] a,
                         input logic [31:0] d, input logic k);
        @(negedge clk);
        cmd = c; bank = b; col = a; dq_in = d; cke = k;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_bus(input string req, input logic exp_oe,
                              input logic [31:0] exp_dq, input bit use_dq);
        n_chk++;
        if (dq_oe !== exp_oe || (use_dq && dq_out !== exp_dq)) begin
            n_err++;
            $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h",
                     req, dq_oe, dq_out, exp_oe, exp_dq);
        end
    endtask

    task automatic wr_burst(input logic [1:0] b, input int s, input logic [1:0] sel,
                            input logic [31:0] seed);
        int bl = 1 << sel;
        burst_sel = sel;
        for (int i = 0; i < bl; i++) begin
            drive(i == 0 ? C_WR : C_NOP, b, 4'(s), seed + 32'(i), 1'b1);
            ref_mem[b][wcol(s, i, bl)] = seed + 32'(i);
        end
    endtask

    task automatic rd_burst(input string req, input logic [1:0] b, input int s,
                            input logic [1:0] sel, input logic cl);
        int bl = 1 << sel;
        burst_sel = sel; cas_sel = cl;
        drive(C_RD, b, 4'(s), 32'h0, 1'b1);
        for (int i = 0; i < (cl ? 2 : 1); i++) begin
            drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
            expect_bus({req, " latency"}, 1'b0, 32'h0, 1'b0);
        end
        for (int i = 0; i < bl; i++) begin
            drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
            expect_bus({req, " beat"}, 1'b1, ref_mem[b][wcol(s, i, bl)], 1'b1);
        end
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus({req, " end"}, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_reset;
        expect_bus("R1 reset", 1'b0, 32'h0, 1'b1);
    endtask

    task automatic t_wrap_bl4;
        wr_burst(2'd1, 6, 2'd2, 32'hA000_0000);
        burst_sel = 2'd0; cas_sel = 1'b0;
        drive(C_RD, 2'd1, 4'd4, 32'h0, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R4 wrap col4", 1'b1, 32'hA000_0002, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        rd_burst("R2 R3 R4 bl4 cl2", 2'd1, 4, 2'd2, 1'b0);
    endtask

    task automatic t_bl8_cl3;
        wr_burst(2'd2, 0, 2'd3, 32'hB000_0000);
        rd_burst("R3 R4 bl8 cl3", 2'd2, 3, 2'd3, 1'b1);
    endtask

    task automatic t_short;
        wr_burst(2'd0, 9, 2'd1, 32'hC000_0000);
        rd_burst("R4 bl2", 2'd0, 9, 2'd1, 1'b0);
        wr_burst(2'd0, 2, 2'd0, 32'hC100_0000);
        rd_burst("R2 bl1", 2'd0, 2, 2'd0, 1'b1);
    endtask

    task automatic t_read_suspend;
        burst_sel = 2'd2; cas_sel = 1'b0;
        drive(C_RD, 2'd1, 4'd4, 32'h0, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R5 beat0", 1'b1, ref_mem[1][4], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b0);
        expect_bus("R5 beat1", 1'b1, ref_mem[1][5], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b0);
        expect_bus("R5 held", 1'b1, ref_mem[1][5], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R5 held twice", 1'b1, ref_mem[1][5], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R10 resume beat2", 1'b1, ref_mem[1][6], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R10 beat3", 1'b1, ref_mem[1][7], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R3 end after suspend", 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_latency_suspend;
        burst_sel = 2'd1; cas_sel = 1'b0;
        drive(C_RD, 2'd1, 4'd4, 32'h0, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b0);
        expect_bus("R8 wait", 1'b0, 32'h0, 1'b0);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R8 suppressed not counted", 1'b0, 32'h0, 1'b0);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R8 beat0", 1'b1, ref_mem[1][4], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R8 beat1", 1'b1, ref_mem[1][5], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R8 end", 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_write_suspend;
        burst_sel = 2'd2; cas_sel = 1'b0;
        drive(C_WR,  2'd3, 4'd0, 32'hD000_0000, 1'b1);
        drive(C_NOP, 2'd3, 4'd0, 32'hD000_0001, 1'b0);
        drive(C_RD,  2'd1, 4'd4, 32'hDEAD_BEEF, 1'b1);
        drive(C_NOP, 2'd3, 4'd0, 32'hD000_0002, 1'b1);
        drive(C_NOP, 2'd3, 4'd0, 32'hD000_0003, 1'b1);
        expect_bus("R7 read at suppressed edge ignored", 1'b0, 32'h0, 1'b0);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R7 still no read data", 1'b0, 32'h0, 1'b0);
        for (int i = 0; i < 4; i++) ref_mem[3][i] = 32'hD000_0000 + 32'(i);
        rd_burst("R6 suppressed write data dropped", 2'd3, 0, 2'd2, 1'b0);
    endtask

    task automatic t_idle_cke;
        for (int i = 0; i < 3; i++) drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b0);
        expect_bus("R9 idle", 1'b0, 32'h0, 1'b0);
        burst_sel = 2'd0;
        drive(C_WR, 2'd3, 4'd10, 32'hE000_000A, 1'b0);
        ref_mem[3][10] = 32'hE000_000A;
        drive(C_RSV, 2'd3, 4'd10, 32'h1234_5678, 1'b0);
        rd_burst("R9 R11 write accepted with cke low", 2'd3, 10, 2'd0, 1'b0);
    endtask

    task automatic t_terminate;
        burst_sel = 2'd3; cas_sel = 1'b0;
        drive(C_RD, 2'd2, 4'd0, 32'h0, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R11 beat0", 1'b1, ref_mem[2][0], 1'b1);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R11 beat1", 1'b1, ref_mem[2][1], 1'b1);
        burst_sel = 2'd0;
        drive(C_WR, 2'd0, 4'd15, 32'hF00D_000F, 1'b1);
        ref_mem[0][15] = 32'hF00D_000F;
        expect_bus("R11 read cut by write", 1'b0, 32'h0, 1'b0);
        drive(C_NOP, 2'd0, 4'd0, 32'h0, 1'b1);
        expect_bus("R11 stays off", 1'b0, 32'h0, 1'b0);
        rd_burst("R11 new write stored", 2'd0, 15, 2'd0, 1'b0);
    endtask

    initial begin
        #(4 * 20000);
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; cke = 1'b1; cmd = C_NOP; bank = 2'd0; col = 4'd0;
        burst_sel = 2'd0; cas_sel = 1'b0; dq_in = 32'h0;
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < 16; c++) ref_mem[b][c] = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_wrap_bl4();
        t_bl8_cl3();
        t_short();
        t_read_suspend();
        t_latency_suspend();
        t_write_suspend();
        t_idle_cke();
        t_terminate();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule